// File: doc/BRIEF.md
# Sub-Pixel Sensor Clock Edge Generator

This block produces the fast clocks that a sensor needs inside each pixel period. It runs on a fast clock at 48 times the pixel rate, so every pixel period has 48 edge positions, numbered 0 to 47. Programmed edge settings control three level outputs: a reset-gate clock and two horizontal clocks, each with a rise position, a fall position and an inversion bit. The block also drives the complement of each horizontal clock and two one-cycle sample strobes, one for the reference level and one for the data level.

Each edge setting is a 6-bit quadrant code. The upper two bits pick a group of twelve positions and the lower four bits pick an offset inside that group. Configuration is held in a shadow copy that reloads only at a pixel-period boundary, so a write during a period cannot cut a pulse short. A blanking input overrides the horizontal clocks with a fixed pattern whose sense comes from a mask input. Two 3-bit drive settings provide the output enables for the external drivers.

Top module: `subpix_clkgen`

## Requirements
- R1: An internal position counter steps 0,1,...,47 and then returns to 0. When `pix_start_i` is high at a clock edge, the position after that edge is 0.
- R2: An edge code c decodes to position 12*c[5:4] + c[3:0]. A low nibble of 12 to 15 is clamped to 11, so code 0x0E gives 11 and 0x3F gives 47.
- R3: With rise position r and fall position f, a clock (before inversion) is high at position p when r<f and r<=p<f, or when r>f and (p>=r or p<f). It is low at every position when r==f.
- R4: The inversion bit, when 1, inverts the reset-gate, first or third clock output.
- R5: Outside blanking, `h2_o` is always the complement of `h1_o` and `h4_o` the complement of `h3_o`.
- R6: While `hblank_i` is 1 and `hmask_i` is 1, `h1_o`=`h3_o`=0 and `h2_o`=`h4_o`=1 in the same cycle.
- R7: While `hblank_i` is 1 and `hmask_i` is 0, `h1_o`=`h3_o`=1 and `h2_o`=`h4_o`=0 in the same cycle.
- R8: `shp_o` and `shd_o` are each high for exactly the cycle whose position equals their decoded setting.
- R9: Edge and strobe settings are captured at the edge that moves the counter to position 0 (a wrap from 47 or a `pix_start_i`). A change at any other time has no effect until then.
- R10: `rg_oe_o` is 0 when `rg_drive_i` is 0 and 1 otherwise. `h_oe_o` follows `h_drive_i` in the same way.
- R11: After reset, the position is 0 and the settings are the defaults: reset gate rises at 0 and falls at 12, both horizontal clocks rise at 0 and fall at 24, none inverted, reference strobe at 24, data strobe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_start_i | input | 1 | Restart the pixel period at position 0 |
| rg_rise_i | input | 6 | Reset-gate rise code |
| rg_fall_i | input | 6 | Reset-gate fall code |
| rg_inv_i | input | 1 | Reset-gate inversion |
| h1_rise_i | input | 6 | First horizontal clock rise code |
| h1_fall_i | input | 6 | First horizontal clock fall code |
| h1_inv_i | input | 1 | First horizontal clock inversion |
| h3_rise_i | input | 6 | Third horizontal clock rise code |
| h3_fall_i | input | 6 | Third horizontal clock fall code |
| h3_inv_i | input | 1 | Third horizontal clock inversion |
| shp_pos_i | input | 6 | Reference-level strobe code |
| shd_pos_i | input | 6 | Data-level strobe code |
| hblank_i | input | 1 | Horizontal blanking override |
| hmask_i | input | 1 | Blanking pattern select |
| rg_drive_i | input | 3 | Reset-gate drive setting |
| h_drive_i | input | 3 | Horizontal driver setting |
| rg_o | output | 1 | Reset-gate clock |
| h1_o | output | 1 | First horizontal clock |
| h2_o | output | 1 | Complement of first horizontal clock |
| h3_o | output | 1 | Third horizontal clock |
| h4_o | output | 1 | Complement of third horizontal clock |
| shp_o | output | 1 | Reference-level sample strobe |
| shd_o | output | 1 | Data-level sample strobe |
| rg_oe_o | output | 1 | Reset-gate output enable |
| h_oe_o | output | 1 | Horizontal output enable |

## Verification
The two events that can land on the same clock edge are a restart of the pixel period by `pix_start_i` and a change of the settings. A restart reloads the shadow copy at once, so new settings must show up right after a mid-period restart and nowhere else. The bench changes the settings at position 20 and observes that nothing moves, then raises `pix_start_i` mid-period, on position 47 and on several cycles in a row, and in each case compares every output with a behavioural model of the counter and the shadow. Blanking is toggled on cycles where strobes and clock edges also occur, and those outputs are judged by the same model.

// File: rtl/subpix_pkg.sv
// Shared constants and types for the sub-pixel clock edge generator.
// Assumes four quadrants of twelve positions per pixel period.
package subpix_pkg;
    localparam int QUAD_SLOTS = 12;
    localparam int QUADS      = 4;
    localparam int POS_COUNT  = QUADS * QUAD_SLOTS;
    localparam int POS_W      = $clog2(POS_COUNT);
    localparam int ENC_W      = 6;
    localparam int NUM_CH     = 3;
    localparam int NUM_STB    = 2;

    typedef logic [ENC_W-1:0] enc_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        enc_t rise;
        enc_t fall;
        logic inv;
    } edge_cfg_t;

    typedef struct packed {
        edge_cfg_t rg;
        edge_cfg_t h1;
        edge_cfg_t h3;
        enc_t      shp;
        enc_t      shd;
    } timing_cfg_t;

    localparam timing_cfg_t CFG_DEFAULT = '{
        rg:  '{rise: 6'd0, fall: 6'd16, inv: 1'b0},
        h1:  '{rise: 6'd0, fall: 6'd32, inv: 1'b0},
        h3:  '{rise: 6'd0, fall: 6'd32, inv: 1'b0},
        shp: 6'd32,
        shd: 6'd0
    };
endpackage

// File: rtl/subpix_pos_decode.sv
// Turns a quadrant code into a linear position 0..47.
// Assumes the upper two bits pick the quadrant; offsets above the
// last slot of a quadrant are clamped onto that last slot.
module subpix_pos_decode
    import subpix_pkg::*;
(
    input  enc_t code_i,
    output pos_t pos_o
);
    logic [3:0] off_raw;
    logic [3:0] off_cl;

    // Clamp the offset and scale the quadrant index.
    always_comb begin
        off_raw = code_i[3:0];
        off_cl  = (off_raw > 4'(QUAD_SLOTS - 1)) ? 4'(QUAD_SLOTS - 1) : off_raw;
        pos_o   = pos_t'(code_i[5:4]) * pos_t'(QUAD_SLOTS) + pos_t'(off_cl);
    end
endmodule

// File: rtl/subpix_phase_ctr.sv
// Position counter inside one pixel period.
// Assumes restart_i may arrive at any position; wrap_o marks the
// edge after which the position is zero.
module subpix_phase_ctr #(
    parameter int COUNT = 48,
    localparam int W    = $clog2(COUNT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    output logic [W-1:0] pos_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(COUNT - 1);

    // Flag the edge that returns the count to zero.
    assign wrap_o = restart_i || (pos_o == LAST);

    // Advance, wrap or restart the position.
    always_ff @(posedge clk) begin
        if (!rst_n)      pos_o <= '0;
        else if (wrap_o) pos_o <= '0;
        else             pos_o <= pos_o + 1'b1;
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= LAST); // R1
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pos_o == '0)); // R1
endmodule

// File: rtl/subpix_cfg_shadow.sv
// Shadow copy of the timing settings, reloaded only on load_i.
// Assumes load_i is high on the edge that starts a pixel period.
module subpix_cfg_shadow #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] cfg_o
);
    // Capture the live settings at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_o <= RST_VAL;
        else if (load_i) cfg_o <= cfg_i;
    end
endmodule

// File: rtl/subpix_edge_wave.sv
// Level of one programmable clock at the current position.
// Assumes rise and fall are already decoded; equal positions give low.
module subpix_edge_wave
    import subpix_pkg::*;
(
    input  pos_t pos_i,
    input  pos_t rise_i,
    input  pos_t fall_i,
    input  logic inv_i,
    output logic lvl_o
);
    logic active;

    // Decide whether the position lies in the high window.
    always_comb begin
        if (rise_i < fall_i)      active = (pos_i >= rise_i) && (pos_i < fall_i);
        else if (rise_i > fall_i) active = (pos_i >= rise_i) || (pos_i < fall_i);
        else                      active = 1'b0;
        lvl_o = active ^ inv_i;
    end
endmodule

// File: rtl/subpix_clkgen.sv
// Sub-pixel clock edge generator: reset-gate clock, two horizontal
// clock pairs and two sample strobes from quadrant-coded settings.
// Assumes clk runs at 48 times the pixel rate; blanking and drive
// settings act at once, edge settings at the next period boundary.
module subpix_clkgen
    import subpix_pkg::*;
#(
    parameter int DRV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_start_i,
    input  logic [5:0]       rg_rise_i,
    input  logic [5:0]       rg_fall_i,
    input  logic             rg_inv_i,
    input  logic [5:0]       h1_rise_i,
    input  logic [5:0]       h1_fall_i,
    input  logic             h1_inv_i,
    input  logic [5:0]       h3_rise_i,
    input  logic [5:0]       h3_fall_i,
    input  logic             h3_inv_i,
    input  logic [5:0]       shp_pos_i,
    input  logic [5:0]       shd_pos_i,
    input  logic             hblank_i,
    input  logic             hmask_i,
    input  logic [DRV_W-1:0] rg_drive_i,
    input  logic [DRV_W-1:0] h_drive_i,
    output logic             rg_o,
    output logic             h1_o,
    output logic             h2_o,
    output logic             h3_o,
    output logic             h4_o,
    output logic             shp_o,
    output logic             shd_o,
    output logic             rg_oe_o,
    output logic             h_oe_o
);
    timing_cfg_t cfg_in;
    timing_cfg_t cfg_q;
    pos_t        pos_q;
    logic        period_wrap;

    assign cfg_in = '{
        rg:  '{rise: rg_rise_i, fall: rg_fall_i, inv: rg_inv_i},
        h1:  '{rise: h1_rise_i, fall: h1_fall_i, inv: h1_inv_i},
        h3:  '{rise: h3_rise_i, fall: h3_fall_i, inv: h3_inv_i},
        shp: shp_pos_i,
        shd: shd_pos_i
    };

    subpix_phase_ctr #(.COUNT(POS_COUNT)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(pix_start_i),
        .pos_o    (pos_q),
        .wrap_o   (period_wrap)
    );

    subpix_cfg_shadow #(.W($bits(timing_cfg_t)), .RST_VAL(CFG_DEFAULT)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(period_wrap),
        .cfg_i (cfg_in),
        .cfg_o (cfg_q)
    );

    edge_cfg_t ch_cfg [NUM_CH];
    logic      ch_lvl [NUM_CH];
    enc_t      stb_code [NUM_STB];
    logic      stb_hit  [NUM_STB];

    assign ch_cfg[0]   = cfg_q.rg;
    assign ch_cfg[1]   = cfg_q.h1;
    assign ch_cfg[2]   = cfg_q.h3;
    assign stb_code[0] = cfg_q.shp;
    assign stb_code[1] = cfg_q.shd;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pos_t rise_pos;
        pos_t fall_pos;
        subpix_pos_decode u_rise (.code_i(ch_cfg[c].rise), .pos_o(rise_pos));
        subpix_pos_decode u_fall (.code_i(ch_cfg[c].fall), .pos_o(fall_pos));
        subpix_edge_wave  u_wave (
            .pos_i (pos_q),
            .rise_i(rise_pos),
            .fall_i(fall_pos),
            .inv_i (ch_cfg[c].inv),
            .lvl_o (ch_lvl[c])
        );
    end

    for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
        pos_t stb_pos;
        subpix_pos_decode u_dec (.code_i(stb_code[s]), .pos_o(stb_pos));
        assign stb_hit[s] = (pos_q == stb_pos);
    end

    // Apply the blanking override and form the complementary pairs.
    always_comb begin
        rg_o  = ch_lvl[0];
        h1_o  = hblank_i ? ~hmask_i : ch_lvl[1];
        h3_o  = hblank_i ? ~hmask_i : ch_lvl[2];
        h2_o  = ~h1_o;
        h4_o  = ~h3_o;
        shp_o = stb_hit[0];
        shd_o = stb_hit[1];
    end

    // Output enables: any nonzero drive setting enables the driver.
    assign rg_oe_o = |rg_drive_i;
    assign h_oe_o  = |h_drive_i;

    AST_BLANK_MASK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_i && hmask_i) |-> (!h1_o && h2_o && !h3_o && h4_o)); // R6
    AST_BLANK_MASK_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_i && !hmask_i) |-> (h1_o && !h2_o && h3_o && !h4_o)); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_wrap |=> $stable(cfg_q)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (shp_o && !period_wrap) |=> !shp_o); // R8
endmodule

// File: tb/subpix_clkgen_tb.sv
// Bench: behavioural model of position and shadowed settings, compared
// against every output on every falling clock edge.
module subpix_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_start = 1'b0;
    logic [5:0] rg_rise, rg_fall, h1_rise, h1_fall, h3_rise, h3_fall, shp_pos, shd_pos;
    logic       rg_inv, h1_inv, h3_inv, hblank, hmask;
    logic [2:0] rg_drive, h_drive;
    logic       rg, h1, h2, h3, h4, shp, shd, rg_oe, h_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string phase = "R11";

    // Model state
    int         m_pos;
    logic [5:0] m_rise [3];
    logic [5:0] m_fall [3];
    logic       m_inv  [3];
    logic [5:0] m_shp, m_shd;

    always #2.5 clk = ~clk;

    subpix_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .pix_start_i(pix_start),
        .rg_rise_i(rg_rise), .rg_fall_i(rg_fall), .rg_inv_i(rg_inv),
        .h1_rise_i(h1_rise), .h1_fall_i(h1_fall), .h1_inv_i(h1_inv),
        .h3_rise_i(h3_rise), .h3_fall_i(h3_fall), .h3_inv_i(h3_inv),
        .shp_pos_i(shp_pos), .shd_pos_i(shd_pos),
        .hblank_i(hblank), .hmask_i(hmask),
        .rg_drive_i(rg_drive), .h_drive_i(h_drive),
        .rg_o(rg), .h1_o(h1), .h2_o(h2), .h3_o(h3), .h4_o(h4),
        .shp_o(shp), .shd_o(shd), .rg_oe_o(rg_oe), .h_oe_o(h_oe)
    );

    function automatic int dec(input logic [5:0] e);
        int lo;
        lo = int'(e[3:0]);
        if (lo > 11) lo = 11;
        return 12 * int'(e[5:4]) + lo;
    endfunction

    function automatic logic [5:0] enc(input int p);
        return 6'((p / 12) * 16 + (p % 12));
    endfunction

    function automatic logic high_at(input int p, input int r, input int f);
        if (r < f) return (p >= r) && (p < f);
        if (r > f) return (p >= r) || (p < f);
        return 1'b0;
    endfunction

    // Model of the clock edge: reset, period counter and shadow reload.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0;
            m_rise = '{6'd0, 6'd0, 6'd0};
            m_fall = '{6'd16, 6'd32, 6'd32};
            m_inv  = '{1'b0, 1'b0, 1'b0};
            m_shp = 6'd32; m_shd = 6'd0;
        end else begin
            if (pix_start || m_pos == 47) begin
                m_rise = '{rg_rise, h1_rise, h3_rise};
                m_fall = '{rg_fall, h1_fall, h3_fall};
                m_inv  = '{rg_inv, h1_inv, h3_inv};
                m_shp = shp_pos; m_shd = shd_pos;
                m_pos = 0;
            end else begin
                m_pos = m_pos + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) pos=%0d act=%0b exp=%0b", tag, phase, m_pos, act, exp);
        end
    endtask

    task automatic compare_all();
        logic e_rg, e_h1, e_h3;
        e_rg = high_at(m_pos, dec(m_rise[0]), dec(m_fall[0])) ^ m_inv[0];
        e_h1 = hblank ? ~hmask : (high_at(m_pos, dec(m_rise[1]), dec(m_fall[1])) ^ m_inv[1]);
        e_h3 = hblank ? ~hmask : (high_at(m_pos, dec(m_rise[2]), dec(m_fall[2])) ^ m_inv[2]);
        chk("R3 rg", rg, e_rg);
        chk("R3 h1", h1, e_h1);
        chk("R3 h3", h3, e_h3);
        chk("R5 h2", h2, ~e_h1);
        chk("R5 h4", h4, ~e_h3);
        chk("R8 shp", shp, m_pos == dec(m_shp));
        chk("R8 shd", shd, m_pos == dec(m_shd));
        chk("R10 rg_oe", rg_oe, rg_drive != 0);
        chk("R10 h_oe", h_oe, h_drive != 0);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wait_pos(input int p);
        while (m_pos != p) tick(1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Non-default inputs during reset: the defaults must still hold (R11).
        rg_rise = enc(5);  rg_fall = enc(20); rg_inv = 1'b0;
        h1_rise = enc(3);  h1_fall = enc(30); h1_inv = 1'b0;
        h3_rise = enc(10); h3_fall = enc(40); h3_inv = 1'b0;
        shp_pos = enc(17); shd_pos = enc(33);
        hblank = 1'b0; hmask = 1'b1; rg_drive = 3'd4; h_drive = 3'd7;
        repeat (3) @(negedge clk);
        chk("R11 rg", rg, 1'b1);
        chk("R11 h1", h1, 1'b1);
        chk("R11 h2", h2, 1'b0);
        chk("R11 shd", shd, 1'b1);
        chk("R11 shp", shp, 1'b0);
        rst_n = 1'b1;
        // First period runs on defaults, the second on the inputs (R9).
        phase = "R11 defaults then R9 load";
        tick(100);

        phase = "R2 clamp";
        rg_rise = 6'h0E; rg_fall = 6'h3F;
        h1_rise = 6'h1D; h1_fall = 6'h2C;
        shp_pos = 6'h3F; shd_pos = 6'h0F;
        tick(100);

        phase = "R3 wrap and equal";
        rg_rise = enc(40); rg_fall = enc(10);
        h1_rise = enc(7);  h1_fall = enc(7);
        h3_rise = enc(47); h3_fall = enc(0);
        tick(100);

        phase = "R4 inversion";
        rg_inv = 1'b1; h1_inv = 1'b1; h3_inv = 1'b1;
        h1_rise = enc(12); h1_fall = enc(36);
        tick(100);

        phase = "R6 R7 blanking";
        rg_inv = 1'b0; h1_inv = 1'b0;
        for (int i = 0; i < 120; i++) begin
            hblank = (i % 7) < 3;
            hmask  = (i % 11) < 5;
            tick(1);
        end
        hblank = 1'b0;

        phase = "R9 mid-period change";
        wait_pos(20);
        rg_rise = enc(1); rg_fall = enc(2); shp_pos = enc(21); shd_pos = enc(22);
        tick(20);
        chk("R9 old settings kept", shp, 1'b0);
        tick(60);

        phase = "R1 restart";
        wait_pos(13);
        pix_start = 1'b1; tick(1); pix_start = 1'b0;
        tick(30);
        wait_pos(47);
        pix_start = 1'b1; tick(1); pix_start = 1'b0;
        tick(5);
        rg_rise = enc(25); shd_pos = enc(1); shp_pos = enc(2);
        wait_pos(30);
        pix_start = 1'b1; tick(3); pix_start = 1'b0;
        tick(60);

        phase = "R8 shared strobe";
        shp_pos = enc(47); shd_pos = enc(47);
        tick(100);

        phase = "R10 drive off";
        rg_drive = 3'd0; h_drive = 3'd1;
        tick(3);
        rg_drive = 3'd2; h_drive = 3'd0;
        tick(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule